// File: doc/BRIEF.md
# SPI Word Byte Packer

This block sits between a byte-oriented data path and a 32-bit word FIFO port of a serial engine whose word length can be set from 4 to 32 bits. The word length arrives as a field that holds the bit count minus one. From it the block works out how many bytes form one serial word, which is between one and four.

On the transmit side the block takes bytes and assembles them into 32-bit words. The first byte of a word goes into the top byte lane and any lanes left over are filled with zeros. On the receive side it takes 32-bit words, which hold their data right-justified to the word size, and returns the bytes most significant first.

A transfer starts with a one-cycle `start` pulse that latches the word length, the number of serial words and a flag saying that no receive data is wanted. Each direction then moves exactly that many words' worth of bytes. With the flag set, received words are still taken in and counted, but no bytes come out. Every stream uses a valid/ready handshake.

Top module: `spi_word_packer`

## Requirements
- R1: Bytes per word equal ceil((cfg_bits_m1 + 1) / 8). The value is latched on `start`, so a field value of 7 gives 1 byte, 15 gives 2, 23 gives 3 and 31 gives 4.
- R2: In a transmit word, byte i of that word sits in bits [31-8i : 24-8i]. The first byte therefore lands in bits 31:24, and every lane above the word size is zero.
- R3: A transmit word is offered once a full word's worth of bytes has been collected. Exactly cfg_words words are offered per transfer.
- R4: For a received word, byte i is taken from bits [8(w-1-i)+7 : 8(w-1-i)], where w is bytes per word. Bytes come out most significant first, and bits above 8w are ignored.
- R5: The total byte count of a transfer is cfg_words times bytes per word. Once that many bytes have been accepted, `tx_byte_ready` stays low, and `rx_word_ready` stays low once cfg_words words have been taken.
- R6: When `cfg_rx_discard` was set at `start`, received words are accepted and counted toward the total but `rx_byte_valid` never rises.
- R7: `done` is high exactly when both directions have reached the total and no transmit word or receive byte is still waiting. After reset the total is zero, so `done` is high and both readies are low.
- R8: While an output valid is high and its ready is low, the valid stays high and its data stays unchanged on the next cycle.
- R9: A `start` pulse clears all counters and drops any waiting transmit word or receive byte on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch configuration and clear the transfer state |
| cfg_bits_m1 | input | 5 | Bits per serial word minus one |
| cfg_words | input | CNT_W | Serial words in the transfer |
| cfg_rx_discard | input | 1 | Consume received words without byte output |
| tx_byte_valid | input | 1 | Transmit byte offered |
| tx_byte_ready | output | 1 | Transmit byte accepted |
| tx_byte | input | 8 | Transmit byte |
| tx_word_valid | output | 1 | Packed word offered to the engine |
| tx_word_ready | input | 1 | Engine takes the packed word |
| tx_word | output | 32 | Packed transmit word |
| rx_word_valid | input | 1 | Received word offered by the engine |
| rx_word_ready | output | 1 | Received word accepted |
| rx_word | input | 32 | Right-justified received word |
| rx_byte_valid | output | 1 | Unpacked byte offered |
| rx_byte_ready | input | 1 | Byte sink takes the byte |
| rx_byte | output | 8 | Unpacked receive byte |
| done | output | 1 | Both directions complete |

## Verification
A wrong lane index shows up on the first word handed out: either a byte sits in the wrong lane of `tx_word`, or `rx_byte` comes out of order within the same word. A wrong count shows up at the end of the transfer, because `done` either rises before the last word has moved or never rises, and a ready stays high beyond the total. The bench keeps its own byte and word queues and compares against them on every handshake and every cycle, so each of these faults is reported within a cycle or two of where it first appears.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES) + 1;

    typedef logic [LANE_W-1:0] lane_cnt_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic { TX_FILL, TX_FULL } tx_state_e;
    typedef enum logic { RX_EMPTY, RX_HOLD } rx_state_e;

    function automatic lane_cnt_t bytes_per_word(input logic [4:0] bits_m1);
        logic [5:0] t;
        t = {1'b0, bits_m1} + 6'd8;
        return lane_cnt_t'(t[5:3]);
    endfunction
endpackage

// File: rtl/spw_tx_packer.sv
module spw_tx_packer
    import spi_pack_pkg::*;
#(
    parameter int TOT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  lane_cnt_t        wsize,
    input  logic [TOT_W-1:0] total,
    input  logic             byte_valid,
    output logic             byte_ready,
    input  byte_t            byte_in,
    output logic             word_valid,
    input  logic             word_ready,
    output word_t            word_out,
    output logic             finished
);
    tx_state_e        state;
    word_t            acc;
    lane_cnt_t        idx;
    logic [TOT_W-1:0] cnt;

    assign byte_ready = (state == TX_FILL) && (cnt < total);
    assign word_valid = (state == TX_FULL);
    assign word_out   = acc;
    assign finished   = (state == TX_FILL) && (cnt == total);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            state <= TX_FILL;
            acc   <= '0;
            idx   <= '0;
            cnt   <= '0;
        end else begin
            if (state == TX_FULL && word_ready) begin
                state <= TX_FILL;
                acc   <= '0;
            end
            if (byte_ready && byte_valid) begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_cnt_t'(l) == idx)
                        acc[(LANES-1-l)*BYTE_W +: BYTE_W] <= byte_in;
                end
                cnt <= cnt + TOT_W'(1);
                if (idx + lane_cnt_t'(1) >= wsize) begin
                    idx   <= '0;
                    state <= TX_FULL;
                end else begin
                    idx <= idx + lane_cnt_t'(1);
                end
            end
        end
    end

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !word_ready && !start) |=> (word_valid && $stable(word_out)));

    // R2
    tx_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && wsize == lane_cnt_t'(1)) |-> (word_out[WORD_W-BYTE_W-1:0] == '0));

    // R5
    tx_no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == total) |-> !byte_ready);
endmodule

// File: rtl/spw_rx_unpacker.sv
module spw_rx_unpacker
    import spi_pack_pkg::*;
#(
    parameter int TOT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  lane_cnt_t        wsize,
    input  logic [TOT_W-1:0] total,
    input  logic             discard,
    input  logic             word_valid,
    output logic             word_ready,
    input  word_t            word_in,
    output logic             byte_valid,
    input  logic             byte_ready,
    output byte_t            byte_out,
    output logic             finished
);
    rx_state_e        state;
    word_t            hold;
    lane_cnt_t        idx;
    lane_cnt_t        lane_sel;
    logic [TOT_W-1:0] cnt;

    assign word_ready = (state == RX_EMPTY) && (cnt < total);
    assign byte_valid = (state == RX_HOLD);
    assign finished   = (state == RX_EMPTY) && (cnt == total);
    assign lane_sel   = wsize - lane_cnt_t'(1) - idx;

    always_comb begin
        byte_out = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_cnt_t'(l) == lane_sel)
                byte_out = hold[l*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            state <= RX_EMPTY;
            hold  <= '0;
            idx   <= '0;
            cnt   <= '0;
        end else if (state == RX_EMPTY) begin
            if (word_ready && word_valid) begin
                if (discard) begin
                    cnt <= cnt + TOT_W'(wsize);
                end else begin
                    hold  <= word_in;
                    idx   <= '0;
                    state <= RX_HOLD;
                end
            end
        end else if (byte_ready) begin
            cnt <= cnt + TOT_W'(1);
            if (idx + lane_cnt_t'(1) >= wsize) begin
                idx   <= '0;
                state <= RX_EMPTY;
            end else begin
                idx <= idx + lane_cnt_t'(1);
            end
        end
    end

    // R6
    rx_discard_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (discard && !start) |=> !byte_valid);

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_ready && !start) |=> (byte_valid && $stable(byte_out)));

    // R5
    rx_no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == total) |-> !word_ready);
endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
    import spi_pack_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [4:0]       cfg_bits_m1,
    input  logic [CNT_W-1:0] cfg_words,
    input  logic             cfg_rx_discard,
    input  logic             tx_byte_valid,
    output logic             tx_byte_ready,
    input  logic [7:0]       tx_byte,
    output logic             tx_word_valid,
    input  logic             tx_word_ready,
    output logic [31:0]      tx_word,
    input  logic             rx_word_valid,
    output logic             rx_word_ready,
    input  logic [31:0]      rx_word,
    output logic             rx_byte_valid,
    input  logic             rx_byte_ready,
    output logic [7:0]       rx_byte,
    output logic             done
);
    localparam int TOT_W = CNT_W + LANE_W;

    lane_cnt_t        wsize_q;
    logic [TOT_W-1:0] total_q;
    logic             discard_q;
    logic             tx_fin;
    logic             rx_fin;
    lane_cnt_t        wsize_d;

    assign wsize_d = bytes_per_word(cfg_bits_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wsize_q   <= lane_cnt_t'(1);
            total_q   <= '0;
            discard_q <= 1'b0;
        end else if (start) begin
            wsize_q   <= wsize_d;
            total_q   <= TOT_W'(cfg_words) * TOT_W'(wsize_d);
            discard_q <= cfg_rx_discard;
        end
    end

    spw_tx_packer #(.TOT_W(TOT_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .wsize      (wsize_q),
        .total      (total_q),
        .byte_valid (tx_byte_valid),
        .byte_ready (tx_byte_ready),
        .byte_in    (tx_byte),
        .word_valid (tx_word_valid),
        .word_ready (tx_word_ready),
        .word_out   (tx_word),
        .finished   (tx_fin)
    );

    spw_rx_unpacker #(.TOT_W(TOT_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .wsize      (wsize_q),
        .total      (total_q),
        .discard    (discard_q),
        .word_valid (rx_word_valid),
        .word_ready (rx_word_ready),
        .word_in    (rx_word),
        .byte_valid (rx_byte_valid),
        .byte_ready (rx_byte_ready),
        .byte_out   (rx_byte),
        .finished   (rx_fin)
    );

    assign done = tx_fin && rx_fin;

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!tx_word_valid && !rx_byte_valid));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!tx_byte_ready && !rx_word_ready && !tx_word_valid && !rx_byte_valid));
endmodule

// File: tb/spi_word_packer_test.sv
module spi_word_packer_test;
    localparam int CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  cfg_bits_m1 = '0;
    logic [CNT_W-1:0] cfg_words = '0;
    logic        cfg_rx_discard = 1'b0;
    logic        tx_byte_valid = 1'b0;
    logic        tx_byte_ready;
    logic [7:0]  tx_byte = '0;
    logic        tx_word_valid;
    logic        tx_word_ready = 1'b0;
    logic [31:0] tx_word;
    logic        rx_word_valid = 1'b0;
    logic        rx_word_ready;
    logic [31:0] rx_word = '0;
    logic        rx_byte_valid;
    logic        rx_byte_ready = 1'b0;
    logic [7:0]  rx_byte;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_word_packer #(.CNT_W(CNT_W)) uut (.*);

    // behavioural model state
    logic [31:0] exp_tx_q[$];
    logic [7:0]  exp_rx_q[$];
    logic [31:0] m_acc;
    int m_idx, ws, total, nwords, tx_in, tx_wout, rx_win;
    logic [31:0] rx_cur;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_xfer(input int bits_m1, input int words, input bit discard);
        bit exp_done, prev_txw_stall, prev_rxb_stall;
        logic [31:0] prev_txw;
        logic [7:0]  prev_rxb;
        @(negedge clk);
        cfg_bits_m1 = 5'(bits_m1);
        cfg_words = CNT_W'(words);
        cfg_rx_discard = discard;
        tx_byte_valid = 0; rx_word_valid = 0; tx_word_ready = 0; rx_byte_ready = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        ws = (bits_m1 + 8) / 8;
        total = words * ws;
        nwords = words;
        tx_in = 0; tx_wout = 0; rx_win = 0; m_idx = 0; m_acc = '0;
        exp_tx_q.delete(); exp_rx_q.delete();
        rx_cur = $urandom;
        prev_txw_stall = 0; prev_rxb_stall = 0;
        prev_txw = '0; prev_rxb = '0;
        // R9: nothing pending right after start
        chk(!tx_word_valid && !rx_byte_valid, "R9 start clears pending", {30'd0, tx_word_valid, rx_byte_valid}, 32'd0);
        for (int cyc = 0; cyc < 4000; cyc++) begin
            exp_done = (tx_in == total) && (tx_wout == nwords) && (rx_win == nwords) && (exp_rx_q.size() == 0);
            chk(done == exp_done, "R7 done", {31'd0, done}, {31'd0, exp_done});
            if (tx_in == total)
                chk(!tx_byte_ready, "R5 tx ready after total", {31'd0, tx_byte_ready}, 32'd0);
            if (rx_win == nwords)
                chk(!rx_word_ready, "R5 rx ready after total", {31'd0, rx_word_ready}, 32'd0);
            if (discard)
                chk(!rx_byte_valid, "R6 discard silent", {31'd0, rx_byte_valid}, 32'd0);
            if (prev_txw_stall)
                chk(tx_word_valid && tx_word == prev_txw, "R8 tx word held", tx_word, prev_txw);
            if (prev_rxb_stall)
                chk(rx_byte_valid && rx_byte == prev_rxb, "R8 rx byte held", {24'd0, rx_byte}, {24'd0, prev_rxb});
            if (exp_done) break;
            tx_byte_valid = ($urandom % 4) != 0;
            tx_byte = 8'(tx_in * 37 + bits_m1 + 5);
            tx_word_ready = ($urandom % 3) != 0;
            rx_word_valid = ($urandom % 4) != 0;
            rx_word = rx_cur;
            rx_byte_ready = ($urandom % 3) != 0;
            #1;
            if (tx_byte_valid && tx_byte_ready) begin
                m_acc = m_acc | (32'(tx_byte) << (8 * (3 - m_idx)));
                m_idx++;
                tx_in++;
                if (m_idx == ws) begin
                    exp_tx_q.push_back(m_acc);
                    m_acc = '0;
                    m_idx = 0;
                end
            end
            if (tx_word_valid && tx_word_ready) begin
                if (exp_tx_q.size() == 0)
                    chk(0, "R3 unexpected tx word", tx_word, 32'd0);
                else
                    chk(tx_word == exp_tx_q[0], "R2 tx word lanes", tx_word, exp_tx_q[0]);
                if (exp_tx_q.size() != 0) void'(exp_tx_q.pop_front());
                tx_wout++;
            end
            if (rx_word_valid && rx_word_ready) begin
                if (!discard)
                    for (int i = 0; i < ws; i++)
                        exp_rx_q.push_back(8'(rx_cur >> (8 * (ws - 1 - i))));
                rx_win++;
                rx_cur = $urandom;
            end
            if (rx_byte_valid && rx_byte_ready) begin
                if (exp_rx_q.size() == 0)
                    chk(0, "R4 unexpected rx byte", {24'd0, rx_byte}, 32'd0);
                else begin
                    chk(rx_byte == exp_rx_q[0], "R4 rx byte order", {24'd0, rx_byte}, {24'd0, exp_rx_q[0]});
                    void'(exp_rx_q.pop_front());
                end
            end
            prev_txw_stall = tx_word_valid && !tx_word_ready;
            prev_txw = tx_word;
            prev_rxb_stall = rx_byte_valid && !rx_byte_ready;
            prev_rxb = rx_byte;
            @(negedge clk);
        end
        // R1 and R3: word count follows the derived bytes per word
        chk(tx_in == total, "R1 bytes accepted", 32'(tx_in), 32'(total));
        chk(tx_wout == nwords, "R3 words emitted", 32'(tx_wout), 32'(nwords));
        chk(done, "R7 done at end", {31'd0, done}, 32'd1);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R7: reset state
        chk(done, "R7 reset done", {31'd0, done}, 32'd1);
        chk(!tx_byte_ready && !rx_word_ready, "R7 reset readies", {30'd0, tx_byte_ready, rx_word_ready}, 32'd0);
        chk(!tx_word_valid && !rx_byte_valid, "R7 reset valids", {30'd0, tx_word_valid, rx_byte_valid}, 32'd0);
        run_xfer(7, 5, 0);
        run_xfer(15, 4, 0);
        run_xfer(31, 3, 0);
        run_xfer(3, 6, 0);
        run_xfer(23, 4, 0);
        run_xfer(11, 3, 0);
        run_xfer(15, 3, 1);
        run_xfer(31, 2, 1);
        run_xfer(31, 5, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule